// File: doc/BRIEF.md
# Serial EEPROM Status and Write-Guard Unit

This unit holds the protection state of a small serial EEPROM: the write-enable latch, a two-bit block-protect level and a protect-enable flag. It turns those registers into the status byte returned by the status-read command, and into two protection decisions. The first says whether the status register may be written now. The second says whether the byte at a given array address may be written. The serial front-end feeds it one-cycle command strobes. The write engine supplies a busy flag that stays high for the whole internal write cycle. The page-write engine asks for an address check through a purely combinational port.

A status write is only staged when it is accepted. The stored bits change at the moment the write cycle finishes, which is the falling edge of busy. At that same point the write-enable latch drops, whether the cycle wrote the status register or the array. The hardware protect pin locks only the status register. Block protection covers a fixed fraction at the top of the array, and it applies whatever the state of the pin, the enable flag or the latch.

Top module: `eep_status_guard`

## Requirements
- R1: After reset the write-enable latch, the protect-enable flag and both block-protect bits are 0. With busy low the status byte reads 0x70.
- R2: With busy low, status bit 7 is the protect-enable flag, bits 6..4 read 1, bit 3 is the upper block-protect bit, bit 2 is the lower block-protect bit, bit 1 is the write-enable latch and bit 0 is 0.
- R3: While busy_i is 1, the status byte reads 0xFF.
- R4: A write-enable strobe sets the latch on the next clock edge. A write-disable strobe clears it. Write-disable wins when both strobes arrive together. Both strobes are ignored while busy_i is 1.
- R5: On the first clock edge at which busy_i is low after being high, the write-enable latch clears. This clear overrides a write-enable strobe in the same cycle.
- R6: hw_lock_o is 1 exactly when wp_ni is 0 and the protect-enable flag is 1.
- R7: wrsr_accept_o is 1 only when wrsr_i is 1, the latch is 1, hw_lock_o is 0 and busy_i is 0. A status write that is not accepted leaves every status bit unchanged.
- R8: An accepted status write stores only data bits 7, 3 and 2. The new values take effect at the end of the next write cycle (R5 edge), and not before.
- R9: The block-protect level decodes as follows: 00 protects no address, 01 protects 0x600–0x7FF, 10 protects 0x400–0x7FF, 11 protects the whole array (0x000–0x7FF).
- R10: addr_wr_ok_o is 1 only when the latch is 1 and chk_addr_i lies outside the protected range. wp_ni and the protect-enable flag have no effect on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wp_ni | input | 1 | Hardware protect pin, active low |
| busy_i | input | 1 | Internal write cycle in progress |
| wren_i | input | 1 | Write-enable command strobe |
| wrdi_i | input | 1 | Write-disable command strobe |
| wrsr_i | input | 1 | Status-write command strobe |
| wrsr_data_i | input | 8 | Data byte of the status write |
| chk_addr_i | input | 11 | Array address to check |
| status_o | output | 8 | Formatted status byte |
| wrsr_accept_o | output | 1 | Status write accepted this cycle |
| addr_wr_ok_o | output | 1 | chk_addr_i may be written |
| hw_lock_o | output | 1 | Hardware status protection active |

## Verification
A wrong latch state shows up in the same cycle at addr_wr_ok_o and at status bit 1 once busy is low. A wrong protect level or enable flag changes the address decision or hw_lock_o right away, and the status byte whenever busy is low. A status write committed too early or too late changes the address decision during the busy window, or the status byte in the first cycle after busy falls. The bench compares all four outputs on every cycle, so any such error is caught within one clock.

// File: rtl/eep_prot_pkg.sv
package eep_prot_pkg;
  localparam int unsigned STAT_W   = 8;
  localparam int unsigned BIT_WPEN = 7;
  localparam int unsigned BIT_BP1  = 3;
  localparam int unsigned BIT_BP0  = 2;
  localparam int unsigned BIT_WEN  = 1;
  localparam int unsigned BIT_RDY  = 0;

  typedef enum logic [1:0] {
    BP_NONE = 2'b00,
    BP_QTR  = 2'b01,
    BP_HALF = 2'b10,
    BP_ALL  = 2'b11
  } bp_level_e;

  typedef struct packed {
    logic      wpen;
    bp_level_e bp;
  } prot_cfg_t;
endpackage

// File: rtl/eep_wen_latch.sv
module eep_wen_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic busy_i,
  input  logic wren_i,
  input  logic wrdi_i,
  input  logic cyc_end_i,
  output logic wen_o
);
  logic wen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wen_q <= 1'b0;
    end else if (cyc_end_i || (wrdi_i && !busy_i)) begin
      wen_q <= 1'b0;
    end else if (wren_i && !busy_i) begin
      wen_q <= 1'b1;
    end
  end

  assign wen_o = wen_q;
endmodule

// File: rtl/eep_prot_regs.sv
module eep_prot_regs
  import eep_prot_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       accept_i,
  input  logic       wpen_i,
  input  logic [1:0] bp_i,
  input  logic       cyc_end_i,
  output prot_cfg_t  cfg_o
);
  prot_cfg_t cfg_q, pend_q;
  logic      pend_vld_q;

  // staged value lands only when the write cycle finishes
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cfg_q      <= '{wpen: 1'b0, bp: BP_NONE};
      pend_q     <= '{wpen: 1'b0, bp: BP_NONE};
      pend_vld_q <= 1'b0;
    end else begin
      if (cyc_end_i && pend_vld_q) cfg_q <= pend_q;
      if (accept_i) begin
        pend_q     <= '{wpen: wpen_i, bp: bp_level_e'(bp_i)};
        pend_vld_q <= 1'b1;
      end else if (cyc_end_i) begin
        pend_vld_q <= 1'b0;
      end
    end
  end

  assign cfg_o = cfg_q;
endmodule

// File: rtl/eep_range_guard.sv
module eep_range_guard
  import eep_prot_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  bp_level_e          bp_i,
  input  logic [ADDR_W-1:0]  addr_i,
  output logic               prot_o
);
  localparam int unsigned TOP = ADDR_W - 1;

  logic in_half, in_qtr;

  generate
    if (ADDR_W >= 2) begin : g_wide
      assign in_half = addr_i[TOP];
      assign in_qtr  = &addr_i[TOP -: 2];
    end else begin : g_narrow
      assign in_half = addr_i[TOP];
      assign in_qtr  = addr_i[TOP];
    end
  endgenerate

  always_comb begin
    unique case (bp_i)
      BP_NONE: prot_o = 1'b0;
      BP_QTR:  prot_o = in_qtr;
      BP_HALF: prot_o = in_half;
      BP_ALL:  prot_o = 1'b1;
      default: prot_o = 1'b1;
    endcase
  end
endmodule

// File: rtl/eep_status_guard.sv
module eep_status_guard
  import eep_prot_pkg::*;
#(
  parameter int unsigned ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wp_ni,
  input  logic              busy_i,
  input  logic              wren_i,
  input  logic              wrdi_i,
  input  logic              wrsr_i,
  input  logic [7:0]        wrsr_data_i,
  input  logic [ADDR_W-1:0] chk_addr_i,
  output logic [7:0]        status_o,
  output logic              wrsr_accept_o,
  output logic              addr_wr_ok_o,
  output logic              hw_lock_o
);
  logic      busy_q, cyc_end;
  logic      wen_q;
  prot_cfg_t cfg;
  logic      wpen_q;
  logic [1:0] bp_q;
  logic      in_block;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_q <= 1'b0;
    else         busy_q <= busy_i;
  end

  assign cyc_end = busy_q && !busy_i;

  eep_wen_latch u_wen (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .busy_i    (busy_i),
    .wren_i    (wren_i),
    .wrdi_i    (wrdi_i),
    .cyc_end_i (cyc_end),
    .wen_o     (wen_q)
  );

  assign hw_lock_o     = !wp_ni && wpen_q;
  assign wrsr_accept_o = wrsr_i && wen_q && !hw_lock_o && !busy_i;

  eep_prot_regs u_regs (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (wrsr_accept_o),
    .wpen_i    (wrsr_data_i[BIT_WPEN]),
    .bp_i      ({wrsr_data_i[BIT_BP1], wrsr_data_i[BIT_BP0]}),
    .cyc_end_i (cyc_end),
    .cfg_o     (cfg)
  );

  assign wpen_q = cfg.wpen;
  assign bp_q   = cfg.bp;

  eep_range_guard #(.ADDR_W(ADDR_W)) u_range (
    .bp_i   (cfg.bp),
    .addr_i (chk_addr_i),
    .prot_o (in_block)
  );

  assign addr_wr_ok_o = wen_q && !in_block;

  always_comb begin
    status_o = 8'h70;
    status_o[BIT_WPEN] = wpen_q;
    status_o[BIT_BP1]  = bp_q[1];
    status_o[BIT_BP0]  = bp_q[0];
    status_o[BIT_WEN]  = wen_q;
    status_o[BIT_RDY]  = 1'b0;
    if (busy_i) status_o = 8'hFF;
  end
endmodule

// File: rtl/eep_prot_chk.sv
module eep_prot_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       busy_i,
  input logic       wren_i,
  input logic       wrdi_i,
  input logic [7:0] status_o,
  input logic       wrsr_accept_o,
  input logic       addr_wr_ok_o,
  input logic       hw_lock_o,
  input logic       wen_q,
  input logic       wpen_q,
  input logic [1:0] bp_q
);
  logic busy_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_seen <= 1'b0;
    else         busy_seen <= busy_i;
  end

  logic fin;
  assign fin = busy_seen && !busy_i;

  p_busy_ff_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> status_o == 8'hFF);

  p_wen_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wren_i && !wrdi_i && !busy_i && !fin) |=> wen_q);

  p_wrdi_busy_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && !wren_i && !fin) |=> $stable(wen_q) || !busy_seen);

  p_wen_drop_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin |=> !wen_q);

  p_lock_blocks_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_lock_o |-> !wrsr_accept_o);

  p_accept_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrsr_accept_o |-> (wen_q && !busy_i));

  p_cfg_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fin |=> ($stable(wpen_q) && $stable(bp_q)));

  p_all_blocked_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bp_q == 2'b11) |-> !addr_wr_ok_o);

  p_needs_wen_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wen_q |-> !addr_wr_ok_o);
endmodule

bind eep_status_guard eep_prot_chk u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .busy_i        (busy_i),
  .wren_i        (wren_i),
  .wrdi_i        (wrdi_i),
  .status_o      (status_o),
  .wrsr_accept_o (wrsr_accept_o),
  .addr_wr_ok_o  (addr_wr_ok_o),
  .hw_lock_o     (hw_lock_o),
  .wen_q         (wen_q),
  .wpen_q        (wpen_q),
  .bp_q          (bp_q)
);

// File: tb/eep_status_guard_tb.sv
`timescale 1ns/1ps
module eep_status_guard_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wp_n = 1'b1, busy = 1'b0, wren = 1'b0, wrdi = 1'b0, wrsr = 1'b0;
  logic [7:0]  wdata = 8'h00;
  logic [10:0] addr = 11'h000;
  logic [7:0]  status;
  logic        accept, wr_ok, lock;

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  eep_status_guard dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wp_ni(wp_n), .busy_i(busy),
    .wren_i(wren), .wrdi_i(wrdi), .wrsr_i(wrsr), .wrsr_data_i(wdata),
    .chk_addr_i(addr), .status_o(status), .wrsr_accept_o(accept),
    .addr_wr_ok_o(wr_ok), .hw_lock_o(lock)
  );

  // behavioural reference state
  int m_wen, m_wpen, m_bp, m_pwpen, m_pbp, m_pvld, m_bprev;

  function automatic int m_locked();
    return (wp_n == 1'b0 && m_wpen == 1) ? 1 : 0;
  endfunction
  function automatic int m_accept();
    return (wrsr && m_wen == 1 && m_locked() == 0 && !busy) ? 1 : 0;
  endfunction
  function automatic int m_status();
    if (busy) return 255;
    return m_wpen * 128 + 112 + m_bp * 4 + m_wen * 2;
  endfunction
  function automatic int m_okaddr(int a);
    int lo;
    case (m_bp)
      0: lo = 2048;
      1: lo = 1536;
      2: lo = 1024;
      default: lo = 0;
    endcase
    return (m_wen == 1 && a < lo) ? 1 : 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_wen = 0; m_wpen = 0; m_bp = 0; m_pwpen = 0; m_pbp = 0; m_pvld = 0; m_bprev = 0;
    end else begin
      int fin, acc;
      fin = (m_bprev == 1 && !busy) ? 1 : 0;
      acc = m_accept();
      if (fin == 1 || (wrdi && !busy)) m_wen = 0;
      else if (wren && !busy) m_wen = 1;
      if (fin == 1 && m_pvld == 1) begin m_wpen = m_pwpen; m_bp = m_pbp; end
      if (acc == 1) begin
        m_pwpen = wdata[7]; m_pbp = wdata[3:2]; m_pvld = 1;
      end else if (fin == 1) m_pvld = 0;
      m_bprev = busy ? 1 : 0;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  // full comparison every cycle, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(busy ? "R3 status" : "R2 status", status, m_status());
      chk("R7 accept", accept, m_accept());
      chk("R6 lock", lock, m_locked());
      chk("R10 addr ok", wr_ok, m_okaddr(addr));
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask
  task automatic at_neg();
    @(negedge clk);
  endtask
  task automatic p_wren();
    wren = 1'b1; tick(); wren = 1'b0;
  endtask
  task automatic p_wrdi();
    wrdi = 1'b1; tick(); wrdi = 1'b0;
  endtask
  task automatic p_wrsr(logic [7:0] d, int exp_acc, string req);
    wrsr = 1'b1; wdata = d; at_neg(); chk(req, accept, exp_acc);
    tick(); wrsr = 1'b0;
  endtask
  task automatic cycle(int n);
    busy = 1'b1; repeat (n) tick(); busy = 1'b0; tick();
  endtask
  task automatic ok_at(logic [10:0] a, int exp, string req);
    addr = a; at_neg(); chk(req, wr_ok, exp);
  endtask

  initial begin
    #(8 * 100000);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst_n = 1'b1; tick();
    at_neg(); chk("R1 reset status", status, 8'h70);
    p_wren(); at_neg(); chk("R4 wren sets", status, 8'h72);
    p_wrdi(); at_neg(); chk("R4 wrdi clears", status, 8'h70);
    wren = 1'b1; wrdi = 1'b1; tick(); wren = 1'b0; wrdi = 1'b0;
    at_neg(); chk("R4 wrdi wins", status, 8'h70);
    p_wren();
    p_wrsr(8'h86, 1, "R7 accept with wen");
    at_neg(); chk("R8 not yet applied", status, 8'h72);
    busy = 1'b1; tick();
    at_neg(); chk("R3 busy reads ff", status, 8'hFF);
    ok_at(11'h7FF, 1, "R8 old level during cycle");
    busy = 1'b0; tick();
    at_neg(); chk("R8 bits 7,3,2 only; R5 wen drop", status, 8'hF4);
    p_wren();
    ok_at(11'h5FF, 1, "R9 quarter below");
    ok_at(11'h600, 0, "R9 quarter edge");
    wp_n = 1'b0; at_neg(); chk("R6 lock on", lock, 1);
    p_wrsr(8'h00, 0, "R7 rejected under lock");
    at_neg(); chk("R7 status unchanged", status, 8'hF6);
    ok_at(11'h000, 1, "R10 pin ignores array");
    wp_n = 1'b1; at_neg(); chk("R6 lock off", lock, 0);
    p_wrsr(8'h08, 1, "R7 accept unlocked");
    cycle(3);
    at_neg(); chk("R8 half level", status, 8'h78);
    p_wren();
    ok_at(11'h3FF, 1, "R9 half below");
    ok_at(11'h400, 0, "R9 half edge");
    p_wrsr(8'h0C, 1, "R7 accept");
    cycle(2);
    p_wren();
    ok_at(11'h000, 0, "R9 all protected");
    p_wrsr(8'h00, 1, "R7 accept clear");
    cycle(2);
    at_neg(); chk("R8 cleared level", status, 8'h70);
    p_wrsr(8'h8C, 0, "R7 rejected without wen");
    p_wren(); busy = 1'b1; p_wrdi();
    ok_at(11'h000, 1, "R4 wrdi ignored while busy");
    busy = 1'b0; tick();
    at_neg(); chk("R5 array cycle clears wen", status, 8'h70);
    ok_at(11'h000, 0, "R10 no wen no write");
    for (int i = 0; i < 2000; i++) begin
      wren  = ($urandom % 6) == 0;
      wrdi  = ($urandom % 14) == 0;
      wrsr  = ($urandom % 5) == 0;
      wdata = 8'($urandom);
      addr  = 11'($urandom);
      if (($urandom % 12) == 0) wp_n = ~wp_n;
      if (($urandom % 5) == 0) busy = ~busy;
      tick();
    end
    wren = 1'b0; wrdi = 1'b0; wrsr = 1'b0; busy = 1'b0;
    repeat (3) tick();
    at_neg();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule